// File: doc/BRIEF.md
# Dual-Rail Two-Bit Full Adder Cell

This cell adds two 2-bit operands and a carry-in. Every bit travels as a rail pair: a true rail and a false rail. A pair holding (1,0) means 1, a pair holding (0,1) means 0, and (0,0) is the spacer, which means no data. The cell returns a 2-bit sum and a carry-out, also as rail pairs. It resolves two bit positions per carry stage, so a chain of these cells has half as many carry hops as a chain of single-bit cells.

Four C-elements join the like-valued rails of each operand bit position. Each C-element rises when both of its inputs are 1, falls when both are 0, and otherwise keeps its last value. In this clocked model the kept value sits in one flop per C-element. The output logic reads the C-element's current value directly, so outputs follow the inputs in the same cycle. The flop only supplies the value held from the previous cycle.

The carry-out uses redundant product terms. When both upper operand bits match, the carry-out is set from those bits alone. When the lower bits agree, the upper sum is set without the carry-in. Only the fully propagating case waits for the carry-in, and it passes through a single AND-OR stage. The outputs drop back to spacer as soon as enough inputs have done so. Handshaking and completion detection are left to the surrounding stage.

Top module: `dr_add2`

## Requirements
- R1: While reset is asserted and all inputs are spacer, every output pair is (0,0). Reset clears the held state of all four C-elements.
- R2: For every valid input (all five rail pairs valid), the outputs give the 3-bit value A+B+CIN in the same cycle. Bit 2 is on (cout_t,cout_f), bit 1 on (sum_t[1],sum_f[1]) and bit 0 on (sum_t[0],sum_f[0]). Each false rail is the complement of its true rail. Index 1 of the operand vectors is the upper bit.
- R3: When a_t[1] and b_t[1] are both 1, cout is (1,0), even while the lower operand pairs and the carry-in are spacer.
- R4: When a_f[1] and b_f[1] are both 1, cout is (0,1), even while the lower operand pairs and the carry-in are spacer.
- R5: When the lower operand bits are valid and equal and the carry-in is spacer, the upper sum pair already equals A[1]^B[1]^(A[0]&B[0]), provided the upper operands are valid.
- R6: While the carry-in is spacer, the lower sum pair is (0,0).
- R7: No output pair ever has both rails at 1.
- R8: When all inputs are spacer, all outputs are spacer in that same cycle.
- R9: After a valid input with both upper operand bits 1, cout stays (1,0) while a_t[1] alone remains high and every other input has returned to spacer.
- R10: When the upper operand bits differ and the lower operand bits differ, the upper sum and the carry-out stay (0,0) until the carry-in arrives. They resolve once the carry-in is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that updates the held C-element state |
| rst_n | input | 1 | Active-low asynchronous reset of the held state |
| a_t | input | 2 | Operand A true rails, index 1 upper |
| a_f | input | 2 | Operand A false rails |
| b_t | input | 2 | Operand B true rails |
| b_f | input | 2 | Operand B false rails |
| cin_t | input | 1 | Carry-in true rail |
| cin_f | input | 1 | Carry-in false rail |
| sum_t | output | 2 | Sum true rails, index 1 upper |
| sum_f | output | 2 | Sum false rails |
| cout_t | output | 1 | Carry-out true rail |
| cout_f | output | 1 | Carry-out false rail |

## Verification
Every output is a same-cycle function of the inputs and the held C-element state. The bench therefore drives each input set just after a falling edge and samples one time unit later, before the next rising edge stores the state. Hold behaviour depends on a value captured at a rising edge. So the bench lets one rising edge pass after a valid input, then releases inputs after the next falling edge and samples there. Each stimulus is preceded by a spacer phase that spans a rising edge, which clears the held state.

// File: rtl/dr_add2.sv
module dr_add2 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] a_t,
  input  logic [1:0] a_f,
  input  logic [1:0] b_t,
  input  logic [1:0] b_f,
  input  logic       cin_t,
  input  logic       cin_f,
  output logic [1:0] sum_t,
  output logic [1:0] sum_f,
  output logic       cout_t,
  output logic       cout_f
);

  // C-element inputs: [0] low both-one, [1] low both-zero, [2] high both-one, [3] high both-zero
  logic [3:0] ce_x, ce_y, ce_out, ce_hold;
  logic lo_p, hi_p, lo_any, hi_any, k_t, k_f;

  assign ce_x   = {a_f[1], a_t[1], a_f[0], a_t[0]};
  assign ce_y   = {b_f[1], b_t[1], b_f[0], b_t[0]};
  assign ce_out = (ce_x & ce_y) | (ce_hold & (ce_x | ce_y));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ce_hold <= '0;
    else        ce_hold <= ce_out;

  assign lo_p   = (a_t[0] & b_f[0]) | (a_f[0] & b_t[0]);
  assign hi_p   = (a_t[1] & b_f[1]) | (a_f[1] & b_t[1]);
  assign lo_any = ce_out[0] | ce_out[1];
  assign hi_any = ce_out[2] | ce_out[3];

  assign sum_t[0] = (lo_any & cin_t) | (lo_p & cin_f);
  assign sum_f[0] = (lo_any & cin_f) | (lo_p & cin_t);

  assign k_t = ce_out[0] | (lo_p & cin_t);
  assign k_f = ce_out[1] | (lo_p & cin_f);

  assign sum_t[1] = (hi_any & k_t) | (hi_p & k_f);
  assign sum_f[1] = (hi_any & k_f) | (hi_p & k_t);

  assign cout_t = ce_out[2] | (hi_p & ce_out[0]) | (hi_p & lo_p & cin_t);
  assign cout_f = ce_out[3] | (hi_p & ce_out[1]) | (hi_p & lo_p & cin_f);

  assert_gen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_t[1] && b_t[1]) |-> (cout_t && !cout_f));
  assert_kill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_f[1] && b_f[1]) |-> (cout_f && !cout_t));
  assert_cin_spacer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cin_t && !cin_f) |-> (sum_t[0] == 1'b0 && sum_f[0] == 1'b0));
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sum_t[0] && sum_f[0]) && !(sum_t[1] && sum_f[1]) && !(cout_t && cout_f));
  assert_spacer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_t == 2'b00 && a_f == 2'b00 && b_t == 2'b00 && b_f == 2'b00 && !cin_t && !cin_f)
      |-> (sum_t == 2'b00 && sum_f == 2'b00 && !cout_t && !cout_f));
  assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_t ^ a_f) == 2'b11 && (b_t ^ b_f) == 2'b11 && (cin_t ^ cin_f))
      |-> ((sum_t ^ sum_f) == 2'b11 && (cout_t ^ cout_f)));

endmodule

// File: tb/dr_add2_test.sv
module dr_add2_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
  logic cin_t = 1'b0, cin_f = 1'b0;
  logic [1:0] sum_t, sum_f;
  logic cout_t, cout_f;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dr_add2 uut (
    .clk(clk), .rst_n(rst_n), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .cin_t(cin_t), .cin_f(cin_f), .sum_t(sum_t), .sum_f(sum_f),
    .cout_t(cout_t), .cout_f(cout_f)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] outs();
    return {sum_t, sum_f, cout_t, cout_f};
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] at, input logic [1:0] af, input logic [1:0] bt,
                       input logic [1:0] bf, input logic ct, input logic cf);
    @(negedge clk);
    a_t = at; a_f = af; b_t = bt; b_f = bf; cin_t = ct; cin_f = cf;
    #1;
  endtask

  task automatic spacer();
    drive(2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0);
    check("R8 all spacer", outs(), 6'b0);
    @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", outs(), 6'b0);
    rst_n = 1'b1;
    @(posedge clk);

    for (int v = 0; v < 32; v++) begin
      logic [1:0] a, b;
      logic c;
      logic [2:0] s;
      a = v[4:3]; b = v[2:1]; c = v[0];
      s = 3'(a) + 3'(b) + 3'(c);
      spacer();
      drive(a, ~a, b, ~b, c, ~c);
      check("R2 valid sum", outs(), {s[1:0], ~s[1:0], s[2], ~s[2]});
      @(posedge clk);
      drive(a, ~a, b, ~b, 1'b0, 1'b0);
      check("R6 low sum spacer", {4'b0, sum_t[0], sum_f[0]}, 6'b0);
      @(posedge clk);
    end

    for (int h = 0; h < 2; h++) begin
      spacer();
      drive({h[0], 1'b0}, {~h[0], 1'b0}, {h[0], 1'b0}, {~h[0], 1'b0}, 1'b0, 1'b0);
      if (h == 1) check("R3 early carry true", {4'b0, cout_t, cout_f}, 6'b000010);
      else        check("R4 early carry false", {4'b0, cout_t, cout_f}, 6'b000001);
    end

    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a[0] == b[0]) begin
          logic e;
          e = a[1] ^ b[1] ^ (a[0] & b[0]);
          spacer();
          drive(a[1:0], ~a[1:0], b[1:0], ~b[1:0], 1'b0, 1'b0);
          check("R5 upper sum without carry-in", {4'b0, sum_t[1], sum_f[1]}, {4'b0, e, ~e});
        end
      end
    end

    spacer();
    drive(2'b10, 2'b01, 2'b01, 2'b10, 1'b0, 1'b0);
    check("R10 waits for carry-in", {4'b0, sum_t[1], sum_f[1], cout_t, cout_f}, 6'b0);
    drive(2'b10, 2'b01, 2'b01, 2'b10, 1'b1, 1'b0);
    check("R10 resolves on carry-in", outs(), {2'b00, 2'b11, 2'b10});

    spacer();
    drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b0, 1'b1);
    @(posedge clk);
    drive(2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0);
    check("R9 carry held", {4'b0, cout_t, cout_f}, 6'b000010);
    spacer();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule